// File: doc/BRIEF.md
# Serial Flash Status and Protection Controller

This block is the control slice of a serial NOR flash slave. It watches an SPI link in mode 0 (clock idles low, the host samples on the rising edge), assembles instruction bytes, and keeps the one-byte status word that the host polls. That word holds a busy flag, a write-enable latch, a three-bit protect level and a bit that locks the status word. Write-status, page-program, sector-erase and bulk-erase requests pass through this block. It rejects a request when the latch is clear, when the target lies in the protected range, or when the status word is locked by hardware. A request that passes starts a busy period of fixed length and sends a one-cycle request pulse to the array logic.

The SPI pins are sampled with the fast system clock. The SPI clock is assumed to run at no more than one eighth of the system clock. The write-protect input is assumed to be synchronous and quiet while chip select is low. The memory array and true non-volatile storage lie outside the block. The protect level and the lock bit are reset along with everything else.

Top module: `flash_status_ctrl`

## Requirements
- R1: The status byte read over SPI is {LOCK, 0, 0, PROT[2:0], WEN, BUSY}, MSB to LSB. Bits 6 and 5 always read 0. After reset, every bit of the status byte is 0.
- R2: Opcode 0x05 is accepted at any time, including while BUSY is 1. After it, the status byte is shifted out MSB first and is sent again after every 8 clocks for as long as chip select stays low. The data-out enable is 0 while the opcode is being shifted in and while chip select is high.
- R3: BUSY reads 1 from the cycle a write-status, program or erase request is accepted until its parameterized duration has elapsed, and 0 otherwise.
- R4: Opcode 0x06 sets WEN and opcode 0x04 clears WEN, but only when chip select rises after exactly one whole byte.
- R5: When WEN is 0, write-status (0x01), page-program (0x02), sector-erase (0xD8) and bulk-erase (0xC7) are rejected with no effect.
- R6: The sector number is address bits [22:16], giving 128 sectors. For PROT in 1..6, sectors at or above 128 - 2^(PROT-1) are protected. PROT=7 protects every sector. Page program (opcode, 3 address bytes, at least 0 data bytes) and sector erase (opcode plus exactly 3 address bytes) are rejected when they target a protected sector.
- R7: Bulk erase (exactly one byte) is accepted only when PROT is 0.
- R8: Write-status takes the opcode plus exactly one data byte. It loads LOCK from data bit 7 and PROT from data bits 4:2. It is rejected while LOCK is 1 and the write-protect input is low, so that LOCK and PROT cannot change.
- R9: Instructions take effect only when chip select rises on a byte boundary. Partial bytes and unknown opcodes change nothing.
- R10: WEN clears when an accepted request's busy period ends. At acceptance, op_start pulses for one cycle with op_kind (0 status write, 1 program, 2 sector erase, 3 bulk erase) and op_addr (the 24-bit address).
- R11: While BUSY is 1, every instruction other than 0x05 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_mosi | input | 1 | Host-to-device serial data |
| spi_miso | output | 1 | Device-to-host serial data |
| spi_miso_oe | output | 1 | Data-out enable; 0 means high impedance |
| wp_n | input | 1 | Write-protect input, active low |
| op_start | output | 1 | One-cycle pulse when a request is accepted |
| op_kind | output | 2 | Kind of the accepted request |
| op_addr | output | 24 | Address of the accepted request |

## Verification
The bench goes after boundary sectors on each side of a protect limit. A design that gets the comparison off by one sector would either program a locked sector or refuse a free one. It sends a frame that ends four bits past a byte boundary, a byte that follows a one-byte opcode, and an unknown opcode. A design that commits on any chip-select rise would change WEN in these cases. It reads the status word twice in one frame while busy and sends a latch clear during that busy period. A design that stops the stream after one byte, or that obeys commands while busy, shows the wrong byte. The lock bit is tested with the write-protect input low and then high, to catch a protect condition that is inverted or ignored.

// File: rtl/fsc_pkg.sv
// Package: opcodes and request kinds shared by the status/protection controller.
// Assumes: one-byte opcodes, 24-bit addresses.
package fsc_pkg;
    localparam logic [7:0] OP_WEN_SET = 8'h06;
    localparam logic [7:0] OP_WEN_CLR = 8'h04;
    localparam logic [7:0] OP_RD_STAT = 8'h05;
    localparam logic [7:0] OP_WR_STAT = 8'h01;
    localparam logic [7:0] OP_PROG    = 8'h02;
    localparam logic [7:0] OP_SECT_ER = 8'hD8;
    localparam logic [7:0] OP_BULK_ER = 8'hC7;

    localparam int ADDR_W = 24;

    typedef enum logic [1:0] {
        JOB_STATUS = 2'd0,
        JOB_PROG   = 2'd1,
        JOB_SECT   = 2'd2,
        JOB_BULK   = 2'd3
    } job_e;
endpackage

// File: rtl/fsc_spi_port.sv
// Module: SPI mode-0 slave front end, oversampled by clk.
// Does: synchronises the pins, assembles bytes, counts whole bytes, detects
//       the end of a frame and streams the status byte after opcode 0x05.
// Assumes: sck at most clk/8; status input is valid at any time.
module fsc_spi_port
    import fsc_pkg::*;
#(
    parameter int CNT_MAX = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic [7:0] status,
    output logic       byte_stb,
    output logic [7:0] byte_val,
    output logic [2:0] byte_pos,
    output logic [2:0] nbytes,
    output logic       frame_end,
    output logic       aligned,
    output logic       miso,
    output logic       miso_oe
);
    logic       cs_d1, cs_d2, sck_d1, sck_d2, mosi_d1;
    logic [2:0] bit_idx;
    logic [7:0] shreg, tx;
    logic       rd_mode;
    logic       active, sck_rise, rd_hit;
    logic [7:0] nxt;

    // Purpose: two-stage pin sampling for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d1 <= 1'b1; cs_d2 <= 1'b1;
            sck_d1 <= 1'b0; sck_d2 <= 1'b0; mosi_d1 <= 1'b0;
        end else begin
            cs_d1 <= cs_n; cs_d2 <= cs_d1;
            sck_d1 <= sck; sck_d2 <= sck_d1; mosi_d1 <= mosi;
        end
    end

    assign active    = ~cs_d1;
    assign sck_rise  = sck_d1 & ~sck_d2;
    assign frame_end = cs_d1 & ~cs_d2;
    assign aligned   = (bit_idx == 3'd0);
    assign nxt       = {shreg[6:0], mosi_d1};
    assign rd_hit    = (nbytes == 3'd0) && (nxt == OP_RD_STAT);

    // Purpose: bit/byte counting, read-stream mode and status reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx <= '0; nbytes <= '0; shreg <= '0; tx <= '0;
            rd_mode <= 1'b0; byte_stb <= 1'b0; byte_val <= '0; byte_pos <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (!active) begin
                bit_idx <= '0;
                nbytes  <= '0;
                rd_mode <= 1'b0;
            end else if (sck_rise) begin
                shreg   <= nxt;
                bit_idx <= bit_idx + 3'd1;
                if (bit_idx == 3'd7) begin
                    byte_stb <= 1'b1;
                    byte_val <= nxt;
                    byte_pos <= nbytes;
                    if (nbytes != 3'(CNT_MAX)) nbytes <= nbytes + 3'd1;
                    if (rd_hit) rd_mode <= 1'b1;
                    if (rd_hit || rd_mode) tx <= status;
                end
            end
        end
    end

    assign miso    = rd_mode & tx[~bit_idx];
    assign miso_oe = rd_mode & active;
endmodule

// File: rtl/fsc_busy_timer.sv
// Module: busy-period timer; loads a per-kind duration on start.
// Does: busy is high while counting; done pulses in the last busy cycle.
// Assumes: start never arrives while busy (the decoder blocks it).
module fsc_busy_timer
    import fsc_pkg::*;
#(
    parameter int T_STAT = 800,
    parameter int T_PROG = 600,
    parameter int T_SECT = 700,
    parameter int T_BULK = 900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  job_e job,
    output logic busy,
    output logic done
);
    localparam int M1   = (T_STAT > T_PROG) ? T_STAT : T_PROG;
    localparam int M2   = (T_SECT > T_BULK) ? T_SECT : T_BULK;
    localparam int TMAX = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(TMAX + 1);

    logic [CW-1:0] cnt, load;

    // Purpose: pick the duration of the requested kind.
    always_comb begin
        unique case (job)
            JOB_STATUS: load = CW'(T_STAT);
            JOB_PROG:   load = CW'(T_PROG);
            JOB_SECT:   load = CW'(T_SECT);
            default:    load = CW'(T_BULK);
        endcase
    end

    // Purpose: down-count the busy period.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (start)           cnt <= load;
        else if (cnt != '0)       cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));
endmodule

// File: rtl/fsc_guard.sv
// Module: instruction decoder, status bits and protection checks.
// Does: captures opcode/address/data, commits at frame end on a byte
//       boundary, gates writes by WEN, protect level, lock bit and wp_n.
// Assumes: wp_n is stable around the end of a frame.
module fsc_guard
    import fsc_pkg::*;
#(
    parameter int SECT_W   = 7,
    parameter int SECT_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb,
    input  logic [7:0]        byte_val,
    input  logic [2:0]        byte_pos,
    input  logic [2:0]        nbytes,
    input  logic              frame_end,
    input  logic              aligned,
    input  logic              wp_n,
    input  logic              busy,
    input  logic              done,
    output logic              go,
    output job_e              go_job,
    output logic [7:0]        status,
    output logic              op_start,
    output job_e              op_kind,
    output logic [ADDR_W-1:0] op_addr
);
    localparam logic [SECT_W:0] ALL_SECT = {1'b1, {SECT_W{1'b0}}};

    logic [7:0]        opc;
    logic [ADDR_W-1:0] addr;
    logic              lock_new, lock, wen;
    logic [2:0]        prot_new, prot;
    logic              set_wen, clr_wen, wr_stat;
    logic [SECT_W:0]   prot_cnt, sector;
    logic              in_prot;

    // Purpose: capture opcode, address bytes and status data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opc <= '0; addr <= '0; lock_new <= 1'b0; prot_new <= '0;
        end else if (byte_stb) begin
            unique case (byte_pos)
                3'd0: opc <= byte_val;
                3'd1: begin
                    addr[23:16] <= byte_val;
                    lock_new    <= byte_val[7];
                    prot_new    <= byte_val[4:2];
                end
                3'd2: addr[15:8] <= byte_val;
                3'd3: addr[7:0]  <= byte_val;
                default: ;
            endcase
        end
    end

    // Purpose: protected-range test of the addressed sector.
    always_comb begin
        sector = {1'b0, addr[SECT_LSB +: SECT_W]};
        if (prot == 3'd7)      prot_cnt = ALL_SECT;
        else if (prot != 3'd0) prot_cnt = (SECT_W+1)'(1) << (prot - 3'd1);
        else                   prot_cnt = '0;
        in_prot = (prot != 3'd0) && (sector >= (ALL_SECT - prot_cnt));
    end

    // Purpose: decide at frame end what the finished instruction does.
    always_comb begin
        go = 1'b0; go_job = JOB_STATUS;
        set_wen = 1'b0; clr_wen = 1'b0; wr_stat = 1'b0;
        if (frame_end && aligned && !busy) begin
            unique case (opc)
                OP_WEN_SET: set_wen = (nbytes == 3'd1);
                OP_WEN_CLR: clr_wen = (nbytes == 3'd1);
                OP_WR_STAT: if (nbytes == 3'd2 && wen && !(lock && !wp_n)) begin
                    wr_stat = 1'b1; go = 1'b1; go_job = JOB_STATUS;
                end
                OP_PROG: if (nbytes >= 3'd4 && wen && !in_prot) begin
                    go = 1'b1; go_job = JOB_PROG;
                end
                OP_SECT_ER: if (nbytes == 3'd4 && wen && !in_prot) begin
                    go = 1'b1; go_job = JOB_SECT;
                end
                OP_BULK_ER: if (nbytes == 3'd1 && wen && prot == 3'd0) begin
                    go = 1'b1; go_job = JOB_BULK;
                end
                default: ;
            endcase
        end
    end

    // Purpose: status bits and the registered request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock <= 1'b0; prot <= '0; wen <= 1'b0;
            op_start <= 1'b0; op_kind <= JOB_STATUS; op_addr <= '0;
        end else begin
            if (done)    wen <= 1'b0;
            if (set_wen) wen <= 1'b1;
            if (clr_wen) wen <= 1'b0;
            if (wr_stat) begin
                lock <= lock_new;
                prot <= prot_new;
            end
            op_start <= go;
            if (go) begin
                op_kind <= go_job;
                op_addr <= addr;
            end
        end
    end

    assign status = {lock, 2'b00, prot, wen, busy};
endmodule

// File: rtl/flash_status_ctrl.sv
// Module: top of the serial flash status and protection controller.
// Does: joins the SPI front end, the decoder/guard and the busy timer.
// Assumes: SPI pins are slow relative to clk; array logic consumes op_*.
module flash_status_ctrl
    import fsc_pkg::*;
#(
    parameter int SECT_W   = 7,
    parameter int SECT_LSB = 16,
    parameter int T_STAT   = 800,
    parameter int T_PROG   = 600,
    parameter int T_SECT   = 700,
    parameter int T_BULK   = 900
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_cs_n,
    input  logic        spi_sck,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic        spi_miso_oe,
    input  logic        wp_n,
    output logic        op_start,
    output logic [1:0]  op_kind,
    output logic [23:0] op_addr
);
    logic       byte_stb, frame_end, aligned, busy, done, go;
    logic [7:0] byte_val, status_w;
    logic [2:0] byte_pos, nbytes;
    job_e       go_job, kind_w;

    fsc_spi_port #(.CNT_MAX(5)) u_port (
        .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck),
        .mosi(spi_mosi), .status(status_w), .byte_stb(byte_stb),
        .byte_val(byte_val), .byte_pos(byte_pos), .nbytes(nbytes),
        .frame_end(frame_end), .aligned(aligned), .miso(spi_miso),
        .miso_oe(spi_miso_oe)
    );

    fsc_guard #(.SECT_W(SECT_W), .SECT_LSB(SECT_LSB)) u_guard (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_val(byte_val),
        .byte_pos(byte_pos), .nbytes(nbytes), .frame_end(frame_end),
        .aligned(aligned), .wp_n(wp_n), .busy(busy), .done(done),
        .go(go), .go_job(go_job), .status(status_w), .op_start(op_start),
        .op_kind(kind_w), .op_addr(op_addr)
    );

    fsc_busy_timer #(.T_STAT(T_STAT), .T_PROG(T_PROG), .T_SECT(T_SECT),
                     .T_BULK(T_BULK)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(go), .job(go_job),
        .busy(busy), .done(done)
    );

    assign op_kind = kind_w;
endmodule

// File: rtl/fsc_checker.sv
// Module: temporal checks for flash_status_ctrl, attached by bind.
// Assumes: status is the live status byte {LOCK,0,0,PROT,WEN,BUSY}.
module fsc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       wp_n,
    input logic       miso_oe,
    input logic       op_start,
    input logic [1:0] op_kind,
    input logic [7:0] status
);
    // R2: no output drive in the cycle after chip select is seen high
    p_oe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !miso_oe);
    // R3: an accepted request is busy in its pulse cycle
    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> status[0]);
    // R5: acceptance needs the write-enable latch set one cycle earlier
    p_start_wen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> $past(status[1]));
    // R7: bulk erase only with protect level zero
    p_bulk_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == 2'd3) |-> ($past(status[4:2]) == 3'd0));
    // R8: hardware lock freezes lock and protect bits
    p_hwprot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && status[7]) |=> $stable(status[7:2]));
    // R10: write-enable latch is clear once busy ends
    p_wen_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> !status[1]);
    // R11: no request is accepted while a busy period runs
    p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> !$past(status[0]));
endmodule

bind flash_status_ctrl fsc_checker u_fsc_checker (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .wp_n(wp_n),
    .miso_oe(spi_miso_oe), .op_start(op_start), .op_kind(op_kind),
    .status(status_w)
);

// File: tb/test_flash_status_ctrl.sv
module test_flash_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic        miso, miso_oe, op_start;
    logic [1:0]  op_kind;
    logic [23:0] op_addr;

    int          checks = 0, fails = 0, nstarts = 0;
    logic [1:0]  last_kind = '0;
    logic [23:0] last_addr = '0;
    bit          finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    flash_status_ctrl i_flash_status_ctrl (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe), .wp_n(wp_n),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr)
    );

    always @(negedge clk) if (rst_n && op_start) begin
        nstarts   = nstarts + 1;
        last_kind = op_kind;
        last_addr = op_addr;
    end

    typedef struct packed {
        logic [39:0] frame;
        logic [5:0]  nbits;
        logic        wp;
        logic [7:0]  exp;
        logic        start;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{{8'h06, 32'h0},               6'd8,  1'b1, 8'h02, 1'b0}, // R4 set
        '{{8'h04, 32'h0},               6'd8,  1'b1, 8'h00, 1'b0}, // R4 clear
        '{{8'h01, 8'h1C, 24'h0},        6'd16, 1'b1, 8'h00, 1'b0}, // R5 no WEN
        '{{8'h06, 32'h0},               6'd8,  1'b1, 8'h02, 1'b0}, // R4
        '{{8'h01, 8'h0C, 24'h0},        6'd16, 1'b1, 8'h0C, 1'b1}, // R8 PROT=3
        '{{8'h06, 32'h0},               6'd8,  1'b1, 8'h0E, 1'b0}, // R4
        '{{8'h02, 24'h7F0000, 8'hAA},   6'd40, 1'b1, 8'h0E, 1'b0}, // R6 sector 127
        '{{8'h02, 24'h7B0000, 8'hAA},   6'd40, 1'b1, 8'h0C, 1'b1}, // R6 sector 123
        '{{8'h06, 32'h0},               6'd8,  1'b1, 8'h0E, 1'b0}, // R4
        '{{8'hC7, 32'h0},               6'd8,  1'b1, 8'h0E, 1'b0}, // R7 blocked
        '{{8'hD8, 24'h7C0000, 8'h00},   6'd32, 1'b1, 8'h0E, 1'b0}, // R6 sector 124
        '{{8'h01, 8'h80, 24'h0},        6'd16, 1'b1, 8'h80, 1'b1}, // R8 LOCK=1
        '{{8'h06, 32'h0},               6'd8,  1'b1, 8'h82, 1'b0}, // R4
        '{{8'hC7, 32'h0},               6'd8,  1'b1, 8'h80, 1'b1}, // R7 accepted
        '{{8'h06, 32'h0},               6'd8,  1'b1, 8'h82, 1'b0}, // R4
        '{{8'h9F, 32'h0},               6'd8,  1'b1, 8'h82, 1'b0}, // R9 unknown
        '{{8'h04, 32'h0},               6'd12, 1'b1, 8'h82, 1'b0}, // R9 partial
        '{{8'h01, 8'h1C, 24'h0},        6'd16, 1'b0, 8'h82, 1'b0}, // R8 locked
        '{{8'h01, 8'h1C, 24'h0},        6'd16, 1'b1, 8'h1C, 1'b1}, // R8 wp high
        '{{8'h06, 32'h0},               6'd8,  1'b1, 8'h1E, 1'b0}, // R4
        '{{8'hD8, 24'h000000, 8'h00},   6'd32, 1'b1, 8'h1E, 1'b0}, // R6 PROT=7
        '{{8'h01, 8'h00, 24'h0},        6'd16, 1'b1, 8'h00, 1'b1}, // R10 WEN drop
        '{{8'h06, 8'h00, 24'h0},        6'd16, 1'b1, 8'h00, 1'b0}, // R4 extra byte
        '{{8'h01, 8'h00, 24'h0},        6'd16, 1'b1, 8'h00, 1'b0}  // R5 no WEN
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One SPI frame, MSB of frame first; collects the last 16 bits of miso.
    task automatic spi_run(input logic [39:0] frame, input int nbits,
                           output logic [15:0] rx, output logic oe_early);
        rx = '0; oe_early = 1'b0;
        @(negedge clk); cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            mosi = frame[39-i];
            repeat (4) @(negedge clk);
            rx = {rx[14:0], miso};
            if (i < 8 && miso_oe) oe_early = 1'b1;
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic read_stat(output logic [7:0] val);
        logic [15:0] rx; logic oe;
        spi_run({8'h05, 32'h0}, 16, rx, oe);
        val = rx[7:0];
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  st;
        logic [15:0] rx;
        logic        oe;
        int          s0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        check("R1 reset oe", {31'd0, miso_oe}, 32'd0);
        check("R1 reset start", {31'd0, op_start}, 32'd0);
        spi_run({8'h05, 32'h0}, 16, rx, oe);
        check("R1 reset status", {24'd0, rx[7:0]}, 32'h00);
        check("R2 hi-z during opcode", {31'd0, oe}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            wp_n = VECS[v].wp;
            s0 = nstarts;
            spi_run(VECS[v].frame, int'(VECS[v].nbits), rx, oe);
            repeat (1100) @(negedge clk);
            wp_n = 1'b1;
            read_stat(st);
            check($sformatf("vector %0d status", v), {24'd0, st}, {24'd0, VECS[v].exp});
            check($sformatf("vector %0d start", v), nstarts - s0, {31'd0, VECS[v].start});
        end

        // R2 R3: repeated stream while busy
        spi_run({8'h06, 32'h0}, 8, rx, oe);
        spi_run({8'h01, 8'h00, 24'h0}, 16, rx, oe);
        check("R10 kind status write", {30'd0, last_kind}, 32'd0);
        spi_run({8'h05, 32'h0}, 24, rx, oe);
        check("R2 R3 two status bytes while busy", {16'd0, rx}, 32'h0303);
        check("R2 oe during stream", {31'd0, oe}, 32'd0);
        // R11: clear-WEN while busy is ignored
        spi_run({8'h04, 32'h0}, 8, rx, oe);
        read_stat(st);
        check("R11 WEN kept while busy", {24'd0, st}, 32'h03);
        repeat (1100) @(negedge clk);
        read_stat(st);
        check("R10 WEN cleared after busy", {24'd0, st}, 32'h00);

        // R10: request pulse carries kind and address
        spi_run({8'h06, 32'h0}, 8, rx, oe);
        s0 = nstarts;
        spi_run({8'hD8, 24'h012345, 8'h00}, 32, rx, oe);
        check("R10 one pulse", nstarts - s0, 32'd1);
        check("R10 kind sector erase", {30'd0, last_kind}, 32'd2);
        check("R10 address", {8'd0, last_addr}, 32'h012345);
        read_stat(st);
        check("R3 busy after erase", {24'd0, st}, 32'h03);
        repeat (1100) @(negedge clk);
        read_stat(st);
        check("R3 idle after erase", {24'd0, st}, 32'h00);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule